// File: doc/BRIEF.md
# Reversible Five-Step Sequence Counter

This block is a three-bit synchronous state counter. It does not count in binary. Its cycle has five codes, and the cycle can be walked in either direction. Two level inputs choose the action taken at each rising clock edge:

- step forward;
- step backward;
- stay put.

Every state bit has its own active-low asynchronous set and clear. These act without a clock edge, so software or a test fixture can force the counter to any three-bit value, including the three codes that are not in the cycle.

A combinational marker output goes high at a particular count, and which count that is depends on the chosen direction. The count is driven out in two forms, a true copy and an inverted copy.

Top module: `bidir_seq_counter`

## Requirements
- R1: With `fwd_i`=1 and `bwd_i`=0, each rising clock edge moves the count `cnt_o` (bit 2 first) through 000, 100, 010, 011, 111 and back to 000.
- R2: With `bwd_i`=1 and `fwd_i`=0, each rising clock edge moves the count through the same five codes in reverse: 000, 111, 011, 010, 100, then 000.
- R3: With both `fwd_i` and `bwd_i` low, a clock edge leaves the count unchanged.
- R4: With both `fwd_i` and `bwd_i` high, a clock edge leaves the count unchanged.
- R5: When the count is 001, 101 or 110 and exactly one direction input is high, the next clock edge loads 000.
- R6: A low on `set_n_i[i]` (while `clr_n_i[i]` is high) drives count bit i to 1 at once, with no clock edge. The bit keeps that value after the set is released.
- R7: A low on `clr_n_i[i]` drives count bit i to 0 at once, with no clock edge. This happens whatever `set_n_i[i]` is doing, so clear wins over set. Clearing all bits is the way the counter leaves its unknown power-up state.
- R8: `special_o` is combinational and goes high only in two cases: the count is 111 and `fwd_i` is high, or the count is 011 and `bwd_i` is high.
- R9: `cnt_n_o` is always the bitwise inverse of `cnt_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock. The count steps on the rising edge. |
| fwd_i | input | 1 | Request to step forward. |
| bwd_i | input | 1 | Request to step backward. |
| set_n_i | input | 3 | Asynchronous set, active low, one bit for each state bit. |
| clr_n_i | input | 3 | Asynchronous clear, active low, one bit for each state bit. Clear has priority over set. |
| cnt_o | output | 3 | Count, active high. |
| cnt_n_o | output | 3 | Count, active low (the inverse of `cnt_o`). |
| special_o | output | 1 | Marker for the direction-dependent special count. |

## Verification
On every clock edge where no asynchronous input is active and the state is known, the assertions check the following:

- the individual forward and backward transitions;
- that the count holds in both idle cases;
- that a stray code is recovered to 000;
- that the marker never rises outside its two allowed counts.

Inside each bit cell, the assertions also check that a sampled clear forces a 0 and that a sampled set alone forces a 1.

Some behaviour can only be shown by the bench scenarios, because the checks must fall between clock edges or span many cycles:

- that set and clear take effect immediately, before any clock edge;
- that clear wins over set;
- the exact value of the marker for every combination of state and direction;
- the inverted outputs;
- long runs through the whole cycle in both directions.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int STATE_W = 3;

    typedef logic [STATE_W-1:0] state_t;

    // Codes of the five-step cycle, in forward order.
    localparam state_t STEP0 = 3'b000;
    localparam state_t STEP1 = 3'b100;
    localparam state_t STEP2 = 3'b010;
    localparam state_t STEP3 = 3'b011;
    localparam state_t STEP4 = 3'b111;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_FWD  = 2'd1,
        MODE_BWD  = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e  mode;
        state_t cnt;
    } step_t;

    typedef struct packed {
        state_t cnt;
        state_t cnt_n;
        logic   special;
    } view_t;

endpackage

// File: rtl/bsc_step_logic.sv
module bsc_step_logic
    import bsc_pkg::*;
(
    input  logic   fwd_i,
    input  logic   bwd_i,
    input  state_t cnt_q,
    output state_t cnt_d
);

    step_t nxt;

    always_comb begin
        nxt.mode = MODE_HOLD;
        if (fwd_i && !bwd_i) nxt.mode = MODE_FWD;
        if (bwd_i && !fwd_i) nxt.mode = MODE_BWD;

        nxt.cnt = cnt_q;
        unique case (nxt.mode)
            MODE_FWD: begin
                case (cnt_q)
                    STEP0:   nxt.cnt = STEP1;
                    STEP1:   nxt.cnt = STEP2;
                    STEP2:   nxt.cnt = STEP3;
                    STEP3:   nxt.cnt = STEP4;
                    STEP4:   nxt.cnt = STEP0;
                    default: nxt.cnt = STEP0;
                endcase
            end
            MODE_BWD: begin
                case (cnt_q)
                    STEP0:   nxt.cnt = STEP4;
                    STEP4:   nxt.cnt = STEP3;
                    STEP3:   nxt.cnt = STEP2;
                    STEP2:   nxt.cnt = STEP1;
                    STEP1:   nxt.cnt = STEP0;
                    default: nxt.cnt = STEP0;
                endcase
            end
            default: nxt.cnt = cnt_q;
        endcase
    end

    assign cnt_d = nxt.cnt;

endmodule

// File: rtl/bsc_flag.sv
module bsc_flag
    import bsc_pkg::*;
(
    input  logic   fwd_i,
    input  logic   bwd_i,
    input  state_t cnt_q,
    output logic   special_o
);

    logic at_fwd_mark;
    logic at_bwd_mark;

    always_comb begin
        at_fwd_mark = (cnt_q == STEP4) && fwd_i;
        at_bwd_mark = (cnt_q == STEP3) && bwd_i;
        special_o   = at_fwd_mark || at_bwd_mark;
    end

endmodule

// File: rtl/bsc_bit_cell.sv
module bsc_bit_cell (
    input  logic clk_i,
    input  logic set_n_i,
    input  logic clr_n_i,
    input  logic d_i,
    output logic q_o
);

    logic bit_d;
    logic bit_q;

    always_comb begin
        bit_d = d_i;
    end

    // Clear has priority over set; both act without the clock.
    always_ff @(posedge clk_i or negedge clr_n_i or negedge set_n_i) begin
        if (!clr_n_i)      bit_q <= 1'b0;
        else if (!set_n_i) bit_q <= 1'b1;
        else               bit_q <= bit_d;
    end

    assign q_o = bit_q;

    // R7: a sampled clear leaves the bit at zero, even with set low.
    assert_clear_wins_R7: assert property (@(posedge clk_i)
        disable iff (set_n_i && clr_n_i)
        !clr_n_i |-> !q_o);

    // R6: a sampled set with no clear leaves the bit at one.
    assert_set_forces_R6: assert property (@(posedge clk_i)
        disable iff (set_n_i && clr_n_i)
        (clr_n_i && !set_n_i) |-> q_o);

endmodule

// File: rtl/bidir_seq_counter.sv
module bidir_seq_counter
    import bsc_pkg::*;
(
    input  logic               clk_i,
    input  logic               fwd_i,
    input  logic               bwd_i,
    input  logic [STATE_W-1:0] set_n_i,
    input  logic [STATE_W-1:0] clr_n_i,
    output logic [STATE_W-1:0] cnt_o,
    output logic [STATE_W-1:0] cnt_n_o,
    output logic               special_o
);

    state_t cnt_d;
    state_t cnt_q;
    logic   flag_w;
    view_t  view;

    bsc_step_logic u_step (
        .fwd_i (fwd_i),
        .bwd_i (bwd_i),
        .cnt_q (cnt_q),
        .cnt_d (cnt_d)
    );

    for (genvar i = 0; i < STATE_W; i++) begin : g_cell
        bsc_bit_cell u_cell (
            .clk_i   (clk_i),
            .set_n_i (set_n_i[i]),
            .clr_n_i (clr_n_i[i]),
            .d_i     (cnt_d[i]),
            .q_o     (cnt_q[i])
        );
    end

    bsc_flag u_flag (
        .fwd_i     (fwd_i),
        .bwd_i     (bwd_i),
        .cnt_q     (cnt_q),
        .special_o (flag_w)
    );

    always_comb begin
        view.cnt     = cnt_q;
        view.cnt_n   = ~cnt_q;
        view.special = flag_w;
    end

    assign cnt_o     = view.cnt;
    assign cnt_n_o   = view.cnt_n;
    assign special_o = view.special;

    logic async_busy;
    assign async_busy = !(&set_n_i) || !(&clr_n_i);

    assert_fwd_wrap_R1: assert property (@(posedge clk_i)
        disable iff (async_busy || $isunknown(cnt_q))
        (fwd_i && !bwd_i && cnt_q == STEP4) |=> (cnt_o == STEP0));

    assert_fwd_mid_R1: assert property (@(posedge clk_i)
        disable iff (async_busy || $isunknown(cnt_q))
        (fwd_i && !bwd_i && cnt_q == STEP1) |=> (cnt_o == STEP2));

    assert_bwd_wrap_R2: assert property (@(posedge clk_i)
        disable iff (async_busy || $isunknown(cnt_q))
        (bwd_i && !fwd_i && cnt_q == STEP0) |=> (cnt_o == STEP4));

    assert_bwd_mid_R2: assert property (@(posedge clk_i)
        disable iff (async_busy || $isunknown(cnt_q))
        (bwd_i && !fwd_i && cnt_q == STEP3) |=> (cnt_o == STEP2));

    assert_idle_hold_R3: assert property (@(posedge clk_i)
        disable iff (async_busy || $isunknown(cnt_q))
        (!fwd_i && !bwd_i) |=> $stable(cnt_o));

    assert_both_hold_R4: assert property (@(posedge clk_i)
        disable iff (async_busy || $isunknown(cnt_q))
        (fwd_i && bwd_i) |=> $stable(cnt_o));

    assert_stray_recover_R5: assert property (@(posedge clk_i)
        disable iff (async_busy || $isunknown(cnt_q))
        ((fwd_i ^ bwd_i) && (cnt_q == 3'b001 || cnt_q == 3'b101 || cnt_q == 3'b110))
        |=> (cnt_o == STEP0));

    assert_flag_scope_R8: assert property (@(posedge clk_i)
        disable iff (async_busy || $isunknown(cnt_q))
        special_o |-> ((fwd_i || bwd_i) && (cnt_o == STEP4 || cnt_o == STEP3)));

endmodule

// File: tb/bidir_seq_counter_test.sv
module bidir_seq_counter_test;

    logic       clk = 1'b0;
    logic       fwd;
    logic       bwd;
    logic [2:0] set_n;
    logic [2:0] clr_n;
    wire  [2:0] cnt;
    wire  [2:0] cnt_n;
    wire        special;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    bidir_seq_counter uut (
        .clk_i     (clk),
        .fwd_i     (fwd),
        .bwd_i     (bwd),
        .set_n_i   (set_n),
        .clr_n_i   (clr_n),
        .cnt_o     (cnt),
        .cnt_n_o   (cnt_n),
        .special_o (special)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic in_cycle(input logic [2:0] v);
        return (v == 3'd0 || v == 3'd4 || v == 3'd2 || v == 3'd3 || v == 3'd7);
    endfunction

    function automatic logic [2:0] model_next(input logic [2:0] v, input logic f, input logic b);
        logic [2:0] order [5];
        order[0] = 3'd0; order[1] = 3'd4; order[2] = 3'd2;
        order[3] = 3'd3; order[4] = 3'd7;
        if (f == b) return v;
        for (int i = 0; i < 5; i++) begin
            if (order[i] == v) return f ? order[(i + 1) % 5] : order[(i + 4) % 5];
        end
        return 3'd0;
    endfunction

    // Force a value asynchronously, keep it across one edge, then release.
    task automatic load(input logic [2:0] v);
        @(negedge clk);
        fwd = 1'b0; bwd = 1'b0;
        set_n = ~v; clr_n = v;
        #1;
        chk("R6 immediate load", cnt, v);
        @(negedge clk);
        set_n = 3'b111; clr_n = 3'b111;
        #1;
        chk("R6 value kept after release", cnt, v);
    endtask

    initial begin
        fwd = 1'b0; bwd = 1'b0; set_n = 3'b111; clr_n = 3'b111;
        repeat (2) @(negedge clk);

        // Leave the unknown power-up state by clearing every bit.
        @(negedge clk);
        clr_n = 3'b000;
        #1;
        chk("R7 reset clear", cnt, 3'b000);
        chk("R9 reset inverse", cnt_n, 3'b111);
        @(negedge clk);
        clr_n = 3'b111;
        #1;
        chk("R7 cleared value kept", cnt, 3'b000);

        // Clear wins over set on bit 1.
        @(negedge clk);
        set_n = 3'b000; clr_n = 3'b101;
        #1;
        chk("R7 clear beats set", cnt, 3'b101);
        @(negedge clk);
        set_n = 3'b111; clr_n = 3'b111;
        #1;
        chk("R7 after clear-vs-set", cnt, 3'b101);

        // Exhaustive sweep: every state, every direction pair.
        for (int v = 0; v < 8; v++) begin
            for (int fb = 0; fb < 4; fb++) begin
                logic f, b;
                logic [2:0] exp;
                string tag;
                f = fb[1]; b = fb[0];
                load(v[2:0]);
                fwd = f; bwd = b;
                #1;
                chk("R8 special flag", {2'b00, special},
                    {2'b00, ((v == 7 && f) || (v == 3 && b))});
                chk("R9 inverse output", cnt_n, ~v[2:0]);
                exp = model_next(v[2:0], f, b);
                if (f == b)            tag = f ? "R4 both high hold" : "R3 idle hold";
                else if (!in_cycle(v[2:0])) tag = "R5 stray code to 000";
                else                   tag = f ? "R1 forward step" : "R2 backward step";
                @(negedge clk);
                #1;
                chk(tag, cnt, exp);
            end
        end

        // Long forward run through more than two full cycles.
        load(3'b000);
        begin
            logic [2:0] exp;
            exp = 3'b000;
            fwd = 1'b1; bwd = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                #1;
                exp = model_next(exp, 1'b1, 1'b0);
                chk("R1 forward run", cnt, exp);
            end
            // Long backward run from wherever forward left off.
            fwd = 1'b0; bwd = 1'b1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                #1;
                exp = model_next(exp, 1'b0, 1'b1);
                chk("R2 backward run", cnt, exp);
            end
            fwd = 1'b0; bwd = 1'b0;
            repeat (3) @(negedge clk);
            #1;
            chk("R3 hold after runs", cnt, exp);
        end

        // Single-bit set on bit 0, no clock edge before the check.
        load(3'b000);
        @(negedge clk);
        set_n = 3'b110;
        #1;
        chk("R6 set bit 0 only", cnt, 3'b001);
        @(negedge clk);
        set_n = 3'b111;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule